// File: doc/BRIEF.md
# Triangle Voice Generator

This block produces one triangle-shaped tone channel for a sound subsystem. Software programs four byte registers over a simple write bus: a linear-counter reload value with a hold flag, the low and high parts of an 11-bit period, and an index into a duration table. A 32-position step sequencer advances once per period of clock-enable pulses. It produces a stepped, symmetric triangle running from -16 to +16 as a signed sample.

Two independent counters decide whether the tone is heard. The first is a 7-bit linear counter driven by quarter-frame ticks. The second is a duration (length) counter driven by half-frame ticks. Neither counter starts counting down straight after a duration write. A latency counter must first run out over a parameterised number of quarter-frame ticks, and it only runs while the hold flag is clear. The frame sequencer that produces the ticks and the mixer that sums channels sit outside this block.

Top module: `tri_voice`

## Requirements
- R1: Writes to address 0 set the linear reload value (bits 6:0) and the hold flag (bit 7). Address 2 sets the period low byte. Address 3 sets period bits 10:8 (data bits 2:0) and the duration index (data bits 7:3). A write to address 1 changes nothing.
- R2: The period is {addr3[2:0], addr2} + 1 clock-enable pulses per sequencer step. While the voice is audible, a step happens on a clock-enable pulse when the step timer is at zero, and the timer then reloads with {addr3[2:0], addr2}. The timer is zero after reset, so the first step comes on the first pulse.
- R3: For step s (0..31), the waveform value is m = 2*s[2:0]. When s[3] is set, it is 16 - m instead. When s[4] is set, the value is negated.
- R4: The held sample changes only on a sequencer step, to the value of the new step. Between steps it holds its value.
- R5: When {addr3[2:0], addr2} is below 3 (period below 4), the sample is 0 and the sequencer does not advance.
- R6: A write to address 3 while the voice is enabled does four things. It loads the duration counter from the table, clears the started flag, sets the latency counter to LATENCY, and reloads the linear counter from address 0. Odd indices give index-1, except index 1, which gives 254. For even indices 0,2,..,14 the values are 10,20,40,80,160,60,14,26, and for 16,..,30 they are 12,24,48,96,192,72,16,32. A write to address 3 while the voice is disabled leaves the duration at 0.
- R7: Before counting has started, each quarter tick with hold clear decrements the latency counter. Counting starts on the tick that finds the latency counter at 1 or 0. While hold is set, counting never starts.
- R8: Once counting has started, each quarter tick decrements a nonzero linear counter. Each half tick decrements a nonzero duration counter, but only while hold is clear.
- R9: A write to address 0 before counting has started reloads the linear counter with data bits 6:0 on the same clock edge.
- R10: While voice_en is low, the duration counter, linear counter, started flag and latency counter are held at zero.
- R11: The sample is 0 whenever the linear counter is 0, or whenever counting has started and the duration counter is 0. len_active is 1 exactly when the duration counter is nonzero.
- R12: After reset, sample is 0 and len_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce | input | 1 | Step-timer clock enable |
| qtr_tick | input | 1 | Quarter-frame tick (latency and linear counter) |
| half_tick | input | 1 | Half-frame tick (duration counter) |
| voice_en | input | 1 | Channel enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| sample | output | 6 | Signed output sample, -16..16 |
| len_active | output | 1 | Duration counter nonzero |

## Verification
The hardest case to reach is silence caused only by the duration counter. For that, the linear counter must still be well above zero, counting must already have started, and the duration counter must have run out. The stimulus reaches it by writing the maximum linear reload and then duration index 3, which loads a count of 2. It waits for the latency ticks to expire and then for two half ticks. The cycle-by-cycle reference model and the bench's explicit checks must both show silence while the linear counter is still far from zero. A second hard case is a linear reload written inside the latency window. The bench places that write between the duration write and the fourth quarter tick.

// File: rtl/tri_voice_pkg.sv
package tri_voice_pkg;

  localparam int LIN_W  = 7;
  localparam int LEN_W  = 8;
  localparam int STEP_W = 5;
  localparam int SMP_W  = 6;

  // duration table: odd indices are index-1 (index 1 is 254),
  // even indices come from two eight-entry rows
  function automatic logic [LEN_W-1:0] len_lookup(input logic [4:0] idx);
    logic [LEN_W-1:0] v;
    if (idx[0]) begin
      v = (idx == 5'd1) ? 8'd254 : ({3'b000, idx} - 8'd1);
    end else if (!idx[4]) begin
      case (idx[3:1])
        3'd0: v = 8'd10;  3'd1: v = 8'd20;  3'd2: v = 8'd40;  3'd3: v = 8'd80;
        3'd4: v = 8'd160; 3'd5: v = 8'd60;  3'd6: v = 8'd14;  default: v = 8'd26;
      endcase
    end else begin
      case (idx[3:1])
        3'd0: v = 8'd12;  3'd1: v = 8'd24;  3'd2: v = 8'd48;  3'd3: v = 8'd96;
        3'd4: v = 8'd192; 3'd5: v = 8'd72;  3'd6: v = 8'd16;  default: v = 8'd32;
      endcase
    end
    return v;
  endfunction

  // triangle value for a sequencer position
  function automatic logic signed [SMP_W-1:0] wave(input logic [STEP_W-1:0] s);
    logic [SMP_W-1:0] mag;
    mag = {2'b00, s[2:0], 1'b0};
    if (s[3]) mag = 6'd16 - mag;
    return s[4] ? -$signed(mag) : $signed(mag);
  endfunction

endpackage

// File: rtl/tri_gate.sv
module tri_gate
  import tri_voice_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             voice_en,
  input  logic             hold,
  input  logic [LIN_W-1:0] lin_reload,
  input  logic             load_len,
  input  logic [4:0]       len_idx,
  input  logic             lin_wr,
  input  logic [LIN_W-1:0] lin_wdata,
  input  logic             qtr_tick,
  input  logic             half_tick,
  output logic [LIN_W-1:0] linear,
  output logic [LEN_W-1:0] length,
  output logic             started,
  output logic             gate_ok
);
  localparam int LAT_W = (LATENCY < 1) ? 1 : $clog2(LATENCY + 1);

  logic [LAT_W-1:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n || !voice_en) begin
      linear  <= '0;
      length  <= '0;
      started <= 1'b0;
      lat     <= '0;
    end else if (load_len) begin
      length  <= len_lookup(len_idx);
      linear  <= lin_reload;
      started <= 1'b0;
      lat     <= LAT_W'(LATENCY);
    end else begin
      if (lin_wr && !started) linear <= lin_wdata;
      if (qtr_tick) begin
        if (!started) begin
          if (!hold) begin
            if (lat != '0) lat <= lat - 1'b1;
            if (lat <= LAT_W'(1)) started <= 1'b1;
          end
        end else if (linear != '0) begin
          linear <= linear - 1'b1;
        end
      end
      if (half_tick && started && !hold && length != '0) length <= length - 1'b1;
    end
  end

  assign gate_ok = (linear != '0) && (!started || length != '0);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !voice_en |=> (length == '0 && linear == '0 && !started));
  a_r6_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_en && load_len) |=> (!started && lat == LAT_W'(LATENCY)));
  a_r7_hold_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_en && !load_len && hold && !started) |=> !started);
  a_r8_linear_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_en && !load_len && qtr_tick && started && linear != '0)
      |=> linear == $past(linear) - 1'b1);
  a_r8_hold_freezes_len: assert property (@(posedge clk) disable iff (!rst_n)
    (voice_en && !load_len && hold) |=> length == $past(length));

endmodule

// File: rtl/tri_seq.sv
module tri_seq
  import tri_voice_pkg::*;
#(
  parameter int PERIOD_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    run,
  input  logic [PERIOD_W-1:0]     period_raw,
  output logic [STEP_W-1:0]       step,
  output logic signed [SMP_W-1:0] held,
  output logic                    step_evt
);
  logic [PERIOD_W-1:0] cnt;

  assign step_evt = run && ce && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      step <= '0;
      held <= '0;
    end else if (run && ce) begin
      if (cnt == '0) begin
        cnt  <= period_raw;
        step <= step + 1'b1;
        held <= wave(step + 1'b1);
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  a_r5_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(step));
  a_r4_held_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(held));
  always_comb begin
    a_r3_range: assert (!rst_n || (held >= -6'sd16 && held <= 6'sd16));
  end

endmodule

// File: rtl/tri_voice.sv
module tri_voice
  import tri_voice_pkg::*;
#(
  parameter int LATENCY  = 4,
  parameter int PERIOD_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    qtr_tick,
  input  logic                    half_tick,
  input  logic                    voice_en,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [7:0]              wr_data,
  output logic signed [SMP_W-1:0] sample,
  output logic                    len_active
);
  localparam int HI_W = PERIOD_W - 8;

  logic [7:0]          r_ctl, r_plo, r_phi;
  logic [PERIOD_W-1:0] period_raw;
  logic [LIN_W-1:0]    linear;
  logic [LEN_W-1:0]    length;
  logic                started, gate_ok, period_ok, audible, step_evt;
  logic [STEP_W-1:0]   step;
  logic signed [SMP_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_ctl <= '0;
      r_plo <= '0;
      r_phi <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    r_ctl <= wr_data;
        2'd2:    r_plo <= wr_data;
        2'd3:    r_phi <= wr_data;
        default: ;
      endcase
    end
  end

  assign period_raw = {r_phi[HI_W-1:0], r_plo};
  assign period_ok  = period_raw >= PERIOD_W'(3);

  tri_gate #(.LATENCY(LATENCY)) u_gate (
    .clk(clk), .rst_n(rst_n), .voice_en(voice_en),
    .hold(r_ctl[7]), .lin_reload(r_ctl[LIN_W-1:0]),
    .load_len(wr_en && wr_addr == 2'd3), .len_idx(wr_data[7:3]),
    .lin_wr(wr_en && wr_addr == 2'd0), .lin_wdata(wr_data[LIN_W-1:0]),
    .qtr_tick(qtr_tick), .half_tick(half_tick),
    .linear(linear), .length(length), .started(started), .gate_ok(gate_ok)
  );

  assign audible = gate_ok && period_ok;

  tri_seq #(.PERIOD_W(PERIOD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce(ce), .run(audible),
    .period_raw(period_raw), .step(step), .held(held), .step_evt(step_evt)
  );

  assign sample     = audible ? held : '0;
  assign len_active = (length != '0);

  a_r11_len_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !len_active) |-> sample == '0);
  a_r11_linear_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (linear == '0) |-> sample == '0);
  a_r5_short_period_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !period_ok |=> $stable(step));

endmodule

// File: tb/sim_tri_voice.sv
module sim_tri_voice;
  localparam int LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, qtr_tick = 1'b0, half_tick = 1'b0, voice_en = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic signed [5:0] sample;
  logic len_active;

  int checks = 0, failures = 0, cyc = 0, tcnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_voice #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .qtr_tick(qtr_tick), .half_tick(half_tick),
    .voice_en(voice_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sample(sample), .len_active(len_active)
  );

  // ---------------- reference model ----------------
  int dur_tab[32] = '{10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,
                      12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30};
  int m_r0, m_r2, m_r3, m_len, m_lin, m_st, m_lat, m_cnt, m_step, m_held;
  int o_lin, o_len, o_st, o_lat, o_raw, o_hold;
  bit o_aud;

  function automatic int tri_val(int s);
    int k;
    k = (s % 8) * 2;
    if ((s / 8) % 2 == 1) k = 16 - k;
    if (s >= 16) k = -k;
    return k;
  endfunction

  function automatic int exp_sample();
    int raw;
    raw = (m_r3 % 8) * 256 + m_r2;
    if (m_lin != 0 && (m_st == 0 || m_len != 0) && raw >= 3) return m_held;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r0 = 0; m_r2 = 0; m_r3 = 0; m_len = 0; m_lin = 0; m_st = 0;
      m_lat = 0; m_cnt = 0; m_step = 0; m_held = 0;
    end else begin
      o_lin = m_lin; o_len = m_len; o_st = m_st; o_lat = m_lat;
      o_raw = (m_r3 % 8) * 256 + m_r2;
      o_hold = m_r0 / 128;
      o_aud = (o_lin != 0) && (o_st == 0 || o_len != 0) && (o_raw >= 3);
      if (ce && o_aud) begin
        if (m_cnt == 0) begin
          m_cnt = o_raw; m_step = (m_step + 1) % 32; m_held = tri_val(m_step);
        end else m_cnt = m_cnt - 1;
      end
      if (!voice_en) begin
        m_len = 0; m_lin = 0; m_st = 0; m_lat = 0;
      end else if (wr_en && wr_addr == 3) begin
        m_len = dur_tab[wr_data / 8]; m_lin = m_r0 % 128; m_st = 0; m_lat = LAT;
      end else begin
        if (wr_en && wr_addr == 0 && o_st == 0) m_lin = wr_data % 128;
        if (qtr_tick) begin
          if (o_st == 0) begin
            if (o_hold == 0) begin
              if (o_lat > 0) m_lat = o_lat - 1;
              if (o_lat <= 1) m_st = 1;
            end
          end else if (o_lin > 0) m_lin = o_lin - 1;
        end
        if (half_tick && o_st == 1 && o_hold == 0 && o_len > 0) m_len = o_len - 1;
      end
      if (wr_en) begin
        if (wr_addr == 0) m_r0 = wr_data;
        if (wr_addr == 2) m_r2 = wr_data;
        if (wr_addr == 3) m_r3 = wr_data;
      end
    end
  end

  // --------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // every-cycle comparison against the model (R2 R3 R4 R11 and others)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(sample) == exp_sample(), "R2/R3/R4/R11 sample", int'(sample), exp_sample());
      chk(len_active == (m_len != 0), "R6/R8/R11 len_active", int'(len_active), int'(m_len != 0));
    end
  end

  // tick and clock-enable generator
  always @(negedge clk) begin
    if (!rst_n) begin
      ce <= 1'b0; qtr_tick <= 1'b0; half_tick <= 1'b0; tcnt <= 0;
    end else begin
      tcnt      <= tcnt + 1;
      ce        <= (tcnt % 3) != 2;
      qtr_tick  <= (tcnt % 37) == 36;
      half_tick <= (tcnt % 74) == 73;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sample == 6'sd0, "R12 reset sample", int'(sample), 0);
    chk(len_active == 1'b0, "R12 reset len_active", int'(len_active), 0);

    // main tone: linear 32, period 16, duration index 1
    voice_en = 1'b1;
    wr(0, 8'h20); wr(2, 8'h0F); wr(3, 8'h08);
    chk(len_active == 1'b1, "R6 duration loaded", int'(len_active), 1);
    idle(600);
    wr(1, 8'hFF);                                  // R1: ignored address
    chk(len_active == 1'b1, "R1 address 1 ignored", int'(len_active), 1);
    idle(1000);
    chk(sample == 6'sd0, "R8 linear expired", int'(sample), 0);

    // hold: counting never starts, duration frozen
    wr(0, 8'h85); wr(3, 8'h08);
    idle(800);
    chk(len_active == 1'b1, "R7 hold keeps duration", int'(len_active), 1);

    // R9: linear reload inside latency window
    wr(0, 8'h7F); wr(3, 8'h08); wr(0, 8'h02);
    idle(450);
    chk(sample == 6'sd0, "R9 short reload expired", int'(sample), 0);
    chk(len_active == 1'b1, "R9 duration still live", int'(len_active), 1);

    // R11: duration runs out while linear still high
    wr(0, 8'h7F); wr(3, 8'h18);
    idle(500);
    chk(len_active == 1'b0, "R11 duration expired", int'(len_active), 0);
    chk(sample == 6'sd0, "R11 silent on duration", int'(sample), 0);

    // R5: short period, then shortest audible period
    wr(0, 8'h7F); wr(2, 8'h02); wr(3, 8'h08);
    idle(60);
    chk(sample == 6'sd0, "R5 inaudible period", int'(sample), 0);
    wr(2, 8'h03);
    idle(300);
    wr(3, 8'h0A);                                  // high period bits
    idle(300);

    // R10: disable clears, write while disabled leaves duration 0
    @(negedge clk); voice_en = 1'b0;
    idle(2);
    chk(len_active == 1'b0, "R10 disable clears", int'(len_active), 0);
    chk(sample == 6'sd0, "R10 disabled silent", int'(sample), 0);
    wr(3, 8'h08);
    chk(len_active == 1'b0, "R6 write while disabled", int'(len_active), 0);
    idle(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule